// File: doc/BRIEF.md
# Dual-Port Hardware Semaphore Unit

This block holds a small set of hardware tokens that two ports, left and right, share to guard common resources. Each port picks one token with an index. A port writes a 0 to ask for the token and a 1 to give it back. It reads a token to learn whether that port currently owns it.

Each token records its holder and whether the other port is waiting for it. A port that asks for a token already held elsewhere is queued. When the holder gives the token back, the token moves to the waiting port on the same clock edge, and software does not have to poll for it.

All state changes on the rising edge of one clock. Reads are combinational from the current state.

Top module: `semUnit`

## Requirements
- R1: There are eight tokens, selected by the index bits [2:0]. An operation on one token leaves every other token unchanged.
- R2: A port reaches the tokens only when its enable is 1 and its active-low semaphore select is 0. Otherwise its writes are ignored and its read data is all zeros.
- R3: A write looks only at data bit 0. A read returns the token's flag on all 16 data bits, so the word is either 16'hFFFF or 16'h0000.
- R4: A free token reads 1 on both ports. Writing 0 to a free token gives it to the writer. The writer then reads 0 and the other port reads 1.
- R5: When a port that does not hold a token writes 0 to it, neither port's read value changes, and the request is recorded as pending. When the holder writes 0, nothing changes.
- R6: When the holder writes 1 while the other port has a request pending, the token moves to the waiting port. The read values of both ports flip, and the pending request is cleared.
- R7: When the holder writes 1 with nothing pending, the token becomes free. A 1 written by a port that does not hold the token releases nothing.
- R8: If both ports write 0 to the same free token in one cycle, the left port gets it and the right request is recorded as pending.
- R9: A port with a pending request withdraws it by writing 1. A later release by the holder then frees the token.
- R10: After reset, all tokens are free and no request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| leftEn | input | 1 | Left port enable, active high |
| leftSemN | input | 1 | Left semaphore select, active low |
| leftWr | input | 1 | Left write (1) or read (0) |
| leftIdx | input | 3 | Left token index |
| leftDin | input | 16 | Left write data; only bit 0 is used |
| leftDout | output | 16 | Left read data |
| rightEn | input | 1 | Right port enable, active high |
| rightSemN | input | 1 | Right semaphore select, active low |
| rightWr | input | 1 | Right write (1) or read (0) |
| rightIdx | input | 3 | Right token index |
| rightDin | input | 16 | Right write data; only bit 0 is used |
| rightDout | output | 16 | Right read data |

## Verification
The bench drives the full hand-over sequence on one token: a request while the token is held, a release that passes the token to the waiting port, then a release to free. A design that dropped the pending request would free the token instead of passing it, and the waiting port would read 1 when it should read 0. The bench also covers a same-cycle collision, a request that is withdrawn and then followed by a release, writes with the select gated off, and data words whose upper bits disagree with bit 0. A design that favoured the wrong side, kept a withdrawn request, or decoded the wrong data bit would show the wrong flag on one of the ports.

// File: rtl/semPkg.sv
package semPkg;
  localparam int SEM_NUM = 8;
  localparam int DATA_W  = 16;

  // Per-token strobes from control to datapath
  typedef struct packed {
    logic req;   // port wrote 0 to this token
    logic rel;   // port wrote 1 to this token
  } portStrobe_t;

  // Per-token state
  typedef struct packed {
    logic held;     // token owned by some port
    logic holderR;  // 1: right owns, 0: left owns
    logic pend;     // the non-holding port is waiting
  } semState_t;
endpackage

// File: rtl/semCtrl.sv
module semCtrl #(
  parameter int NumSem = semPkg::SEM_NUM,
  localparam int IdxW = $clog2(NumSem)
) (
  input  logic leftEn,
  input  logic leftSemN,
  input  logic leftWr,
  input  logic [IdxW-1:0] leftIdx,
  input  logic leftBit,
  input  logic rightEn,
  input  logic rightSemN,
  input  logic rightWr,
  input  logic [IdxW-1:0] rightIdx,
  input  logic rightBit,
  output logic accL,
  output logic accR,
  output semPkg::portStrobe_t [NumSem-1:0] strobeL,
  output semPkg::portStrobe_t [NumSem-1:0] strobeR
);
  assign accL = leftEn & ~leftSemN;
  assign accR = rightEn & ~rightSemN;

  for (genvar i = 0; i < NumSem; i++) begin : g_dec
    logic hitL, hitR;
    assign hitL = accL & leftWr & (leftIdx == IdxW'(i));
    assign hitR = accR & rightWr & (rightIdx == IdxW'(i));
    assign strobeL[i].req = hitL & ~leftBit;
    assign strobeL[i].rel = hitL & leftBit;
    assign strobeR[i].req = hitR & ~rightBit;
    assign strobeR[i].rel = hitR & rightBit;
  end
endmodule

// File: rtl/semBank.sv
module semBank #(
  parameter int NumSem = semPkg::SEM_NUM,
  parameter int DataW  = semPkg::DATA_W,
  localparam int IdxW = $clog2(NumSem)
) (
  input  logic clk,
  input  logic rstN,
  input  semPkg::portStrobe_t [NumSem-1:0] strobeL,
  input  semPkg::portStrobe_t [NumSem-1:0] strobeR,
  input  logic accL,
  input  logic accR,
  input  logic [IdxW-1:0] leftIdx,
  input  logic [IdxW-1:0] rightIdx,
  output logic [DataW-1:0] leftDout,
  output logic [DataW-1:0] rightDout,
  output logic [NumSem-1:0] flagL,
  output logic [NumSem-1:0] flagR,
  output logic [NumSem-1:0] pendVec
);
  import semPkg::*;

  for (genvar i = 0; i < NumSem; i++) begin : g_sem
    semState_t cur, nxt;
    logic pe;

    always_comb begin
      nxt = cur;
      pe  = 1'b0;
      if (!cur.held) begin
        if (strobeL[i].req)      nxt = '{held: 1'b1, holderR: 1'b0, pend: strobeR[i].req};
        else if (strobeR[i].req) nxt = '{held: 1'b1, holderR: 1'b1, pend: 1'b0};
      end else if (!cur.holderR) begin
        pe = (cur.pend | strobeR[i].req) & ~strobeR[i].rel;
        if (strobeL[i].rel) nxt = pe ? '{held: 1'b1, holderR: 1'b1, pend: 1'b0} : '0;
        else                nxt.pend = pe;
      end else begin
        pe = (cur.pend | strobeL[i].req) & ~strobeL[i].rel;
        if (strobeR[i].rel) nxt = pe ? '{held: 1'b1, holderR: 1'b0, pend: 1'b0} : '0;
        else                nxt.pend = pe;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) cur <= '0;
      else       cur <= nxt;
    end

    assign flagL[i]   = ~(cur.held & ~cur.holderR);
    assign flagR[i]   = ~(cur.held & cur.holderR);
    assign pendVec[i] = cur.pend;
  end

  assign leftDout  = accL ? {DataW{flagL[leftIdx]}}  : '0;
  assign rightDout = accR ? {DataW{flagR[rightIdx]}} : '0;
endmodule

// File: rtl/semUnit.sv
module semUnit #(
  parameter int NumSem = semPkg::SEM_NUM,
  parameter int DataW  = semPkg::DATA_W,
  localparam int IdxW = $clog2(NumSem)
) (
  input  logic clk,
  input  logic rstN,
  input  logic leftEn,
  input  logic leftSemN,
  input  logic leftWr,
  input  logic [IdxW-1:0] leftIdx,
  input  logic [DataW-1:0] leftDin,
  output logic [DataW-1:0] leftDout,
  input  logic rightEn,
  input  logic rightSemN,
  input  logic rightWr,
  input  logic [IdxW-1:0] rightIdx,
  input  logic [DataW-1:0] rightDin,
  output logic [DataW-1:0] rightDout
);
  semPkg::portStrobe_t [NumSem-1:0] strobeL, strobeR;
  logic accL, accR;
  logic [NumSem-1:0] flagL, flagR, pendVec;
  logic unusedDin;

  assign unusedDin = ^{leftDin[DataW-1:1], rightDin[DataW-1:1]};

  semCtrl #(.NumSem(NumSem)) u_ctrl (
    .leftEn(leftEn), .leftSemN(leftSemN), .leftWr(leftWr), .leftIdx(leftIdx),
    .leftBit(leftDin[0]),
    .rightEn(rightEn), .rightSemN(rightSemN), .rightWr(rightWr), .rightIdx(rightIdx),
    .rightBit(rightDin[0]),
    .accL(accL), .accR(accR), .strobeL(strobeL), .strobeR(strobeR)
  );

  semBank #(.NumSem(NumSem), .DataW(DataW)) u_bank (
    .clk(clk), .rstN(rstN), .strobeL(strobeL), .strobeR(strobeR),
    .accL(accL), .accR(accR), .leftIdx(leftIdx), .rightIdx(rightIdx),
    .leftDout(leftDout), .rightDout(rightDout),
    .flagL(flagL), .flagR(flagR), .pendVec(pendVec)
  );
endmodule

// File: rtl/semUnitChk.sv
module semUnitChk #(
  parameter int NumSem = 8,
  parameter int DataW  = 16,
  localparam int IdxW = $clog2(NumSem)
) (
  input logic clk,
  input logic rstN,
  input logic leftEn,
  input logic leftSemN,
  input logic leftWr,
  input logic [IdxW-1:0] leftIdx,
  input logic [DataW-1:0] leftDin,
  input logic [DataW-1:0] leftDout,
  input logic rightEn,
  input logic rightSemN,
  input logic [DataW-1:0] rightDout,
  input logic [NumSem-1:0] flagL,
  input logic [NumSem-1:0] flagR,
  input logic [NumSem-1:0] pendVec
);
  logic inL, inR, relL;
  assign inL  = leftEn & ~leftSemN;
  assign inR  = rightEn & ~rightSemN;
  assign relL = inL & leftWr & leftDin[0] & ~inR & ~flagL[leftIdx];

  // R2: with no port selected, no token state moves
  a_r2_idle_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!inL && !inR) |=> $stable({flagL, flagR, pendVec}));

  // R3: read words are all ones or all zeros
  a_r3_replicated: assert property (@(posedge clk) disable iff (!rstN)
    (leftDout == '0 || leftDout == '1) && (rightDout == '0 || rightDout == '1));

  // R5: a pending request only exists on a held token
  a_r5_pend_held: assert property (@(posedge clk) disable iff (!rstN)
    (pendVec & flagL & flagR) == '0);

  // R6: left release with a waiting right request hands over
  a_r6_handover: assert property (@(posedge clk) disable iff (!rstN)
    (relL && pendVec[leftIdx]) |=> (!flagR[$past(leftIdx)] && flagL[$past(leftIdx)]));

  // R7: left release with nothing waiting frees the token
  a_r7_free: assert property (@(posedge clk) disable iff (!rstN)
    (relL && !pendVec[leftIdx]) |=> (flagL[$past(leftIdx)] && flagR[$past(leftIdx)]));
endmodule

bind semUnit semUnitChk #(.NumSem(NumSem), .DataW(DataW)) u_chk (
  .clk(clk), .rstN(rstN),
  .leftEn(leftEn), .leftSemN(leftSemN), .leftWr(leftWr), .leftIdx(leftIdx),
  .leftDin(leftDin), .leftDout(leftDout),
  .rightEn(rightEn), .rightSemN(rightSemN), .rightDout(rightDout),
  .flagL(flagL), .flagR(flagR), .pendVec(pendVec)
);

// File: tb/semUnit_tb.sv
module semUnit_tb;
  localparam int ClkPeriod = 10;
  localparam int NVec = 18;
  // op codes: 0 none, 1 write 0, 2 write 1
  // fields: lOp[14:13] lIdx[12:10] rOp[9:8] rIdx[7:5] chk[4:2] expL[1] expR[0]
  localparam logic [14:0] VEC [NVec] = '{
    {2'd1,3'd3,2'd0,3'd0,3'd3,1'b0,1'b1},  // R4 left grabs
    {2'd0,3'd0,2'd1,3'd3,3'd3,1'b0,1'b1},  // R5 right queues
    {2'd2,3'd3,2'd0,3'd0,3'd3,1'b1,1'b0},  // R6 pass to right
    {2'd1,3'd3,2'd0,3'd0,3'd3,1'b1,1'b0},  // R5 left queues
    {2'd0,3'd0,2'd2,3'd3,3'd3,1'b0,1'b1},  // R6 pass to left
    {2'd2,3'd3,2'd0,3'd0,3'd3,1'b1,1'b1},  // R7 free
    {2'd0,3'd0,2'd1,3'd3,3'd3,1'b1,1'b0},  // R4 right grabs
    {2'd0,3'd0,2'd2,3'd3,3'd3,1'b1,1'b1},  // R7 free
    {2'd0,3'd0,2'd1,3'd5,3'd5,1'b1,1'b0},  // R4
    {2'd2,3'd5,2'd0,3'd0,3'd5,1'b1,1'b0},  // R7 non-holder 1
    {2'd1,3'd5,2'd0,3'd0,3'd5,1'b1,1'b0},  // R5 queue
    {2'd2,3'd5,2'd0,3'd0,3'd5,1'b1,1'b0},  // R9 withdraw
    {2'd0,3'd0,2'd2,3'd5,3'd5,1'b1,1'b1},  // R9 frees
    {2'd1,3'd6,2'd1,3'd6,3'd6,1'b0,1'b1},  // R8 left wins
    {2'd2,3'd6,2'd0,3'd0,3'd6,1'b1,1'b0},  // R8 right pending served
    {2'd0,3'd0,2'd2,3'd6,3'd6,1'b1,1'b1},  // R7
    {2'd1,3'd0,2'd1,3'd7,3'd0,1'b0,1'b1},  // R1 two tokens
    {2'd0,3'd0,2'd0,3'd0,3'd7,1'b1,1'b0}   // R1
  };

  logic clk = 0, rstN = 0;
  logic leftEn = 0, leftSemN = 1, leftWr = 0, rightEn = 0, rightSemN = 1, rightWr = 0;
  logic [2:0] leftIdx = 0, rightIdx = 0;
  logic [15:0] leftDin = 0, rightDin = 0, leftDout, rightDout;
  int nChecks = 0, nFails = 0;
  bit done = 0;

  always #(ClkPeriod/2) clk = ~clk;

  semUnit u_dut (.*);

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic setL(bit en, bit semN, bit wr, logic [2:0] idx, logic [15:0] d);
    leftEn = en; leftSemN = semN; leftWr = wr; leftIdx = idx; leftDin = d;
  endtask
  task automatic setR(bit en, bit semN, bit wr, logic [2:0] idx, logic [15:0] d);
    rightEn = en; rightSemN = semN; rightWr = wr; rightIdx = idx; rightDin = d;
  endtask

  // after an op edge, read index k on both ports and compare
  task automatic readBoth(string req, logic [2:0] k, bit eL, bit eR);
    @(negedge clk);
    setL(1, 0, 0, k, 0); setR(1, 0, 0, k, 0);
    #1;
    check(req, leftDout, {16{eL}});
    check(req, rightDout, {16{eR}});
  endtask

  task automatic opCycle(logic [1:0] lOp, logic [2:0] li, logic [1:0] rOp, logic [2:0] ri);
    @(negedge clk);
    setL(lOp != 0, lOp == 0, lOp != 0, li, {15'h0, lOp == 2});
    setR(rOp != 0, rOp == 0, rOp != 0, ri, {15'h0, rOp == 2});
  endtask

  initial begin
    #(ClkPeriod * 20000);
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rstN = 1;
    // R10: all free after reset
    for (int k = 0; k < 8; k++) readBoth("R10", 3'(k), 1, 1);

    // R2: idle read data is zero
    @(negedge clk); setL(0, 1, 0, 0, 0); setR(1, 1, 0, 0, 0); #1;
    check("R2", leftDout, 16'h0000);
    check("R2", rightDout, 16'h0000);
    // R2: writes with enable low or select high are ignored
    @(negedge clk); setL(0, 0, 1, 3'd1, 0); setR(1, 1, 1, 3'd1, 0);
    readBoth("R2", 3'd1, 1, 1);

    // R3: only bit 0 of write data counts
    @(negedge clk); setL(1, 0, 1, 3'd2, 16'hFFFE); setR(1, 1, 0, 0, 0);
    readBoth("R3", 3'd2, 0, 1);
    @(negedge clk); setL(1, 0, 1, 3'd2, 16'h0001); setR(1, 1, 0, 0, 0);
    readBoth("R3", 3'd2, 1, 1);

    for (int v = 0; v < NVec; v++) begin
      opCycle(VEC[v][14:13], VEC[v][12:10], VEC[v][9:8], VEC[v][7:5]);
      readBoth($sformatf("vec%0d R1/R4-R9", v), VEC[v][4:2], VEC[v][1], VEC[v][0]);
    end

    // R10: reset while tokens are held clears them
    @(negedge clk); rstN = 0;
    @(negedge clk); rstN = 1;
    readBoth("R10", 3'd0, 1, 1);
    readBoth("R10", 3'd7, 1, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule